// File: doc/BRIEF.md
# Paged Memory Write Buffer

This block manages writes into a 256-byte memory that keeps its contents the way a non-volatile array does. The memory is split into 16 pages of 16 bytes. A front end first hands it a starting byte address and then a stream of data bytes. Each byte goes into a one-page staging buffer. The in-page offset advances after every byte and wraps around inside the selected page. A per-offset flag records which staging slots were filled during the current transaction.

A commit strobe starts a timed internal write cycle, provided at least one byte was staged. The block raises `busy` for a fixed, parameterised number of clock cycles, so the front end can refuse new traffic during that time. At the end of the cycle, every flagged slot is copied into its page and all other bytes of the page keep their contents. A combinational read port gives the array contents at any time.

Top module: `page_write_buffer`

## Requirements
- R1: After reset every byte of the array reads 0xFF and `busy` is low.
- R2: An accepted address load takes bits [7:4] of `addr_in` as the page and bits [3:0] as the starting offset, and it clears all staged-byte flags.
- R3: Each accepted byte load stores `byte_in` at the current offset and marks that offset as staged. The offset then advances by one modulo 16, and the page stays the same.
- R4: When more than 16 bytes are loaded, later bytes replace earlier ones at the same offset. The write cycle stores only the most recent value for each offset.
- R5: The write cycle changes only the offsets staged since the last address load or completed write. Every other byte of the array keeps its value.
- R6: A commit while idle, with at least one byte staged, raises `busy` on the next clock edge. `busy` stays high for exactly WR_CYCLES cycles. The array is updated on the edge where `busy` falls, and the staged flags are cleared on that same edge. Reads while `busy` is high return the old contents.
- R7: While `busy` is high, address loads, byte loads and commits are ignored.
- R8: A commit with no byte staged starts no write cycle and leaves `busy` low.
- R9: When a commit is accepted, loads in the same cycle are ignored. An address load takes priority over a byte load in the same cycle.
- R10: `rd_data` equals the array byte at `rd_addr` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load start address strobe |
| addr_in | input | 8 | Start address: page in the upper bits, offset in the lower bits |
| byte_load | input | 1 | Stage one data byte |
| byte_in | input | 8 | Data byte |
| commit | input | 1 | Start the write cycle |
| busy | output | 1 | Write cycle in progress |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The offset-advance and page-hold assertions assume that strobes are single-bit, known and sampled only after reset has been released. The bench drives every strobe at the falling edge and holds it for exactly one cycle. Address, byte and commit strobes are never raised together, except in the scenario written for R9. Loads and commits during `busy` are driven on purpose to exercise R7. Apart from those cases, the bench waits for `busy` to drop before it starts a new transaction.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int PAGE_BITS = 4,
  parameter int OFFS_BITS = 4,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 40,
  parameter logic [DW-1:0] ERASED = 8'hFF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           addr_load,
  input  logic [PAGE_BITS+OFFS_BITS-1:0] addr_in,
  input  logic                           byte_load,
  input  logic [DW-1:0]                  byte_in,
  input  logic                           commit,
  output logic                           busy,
  input  logic [PAGE_BITS+OFFS_BITS-1:0] rd_addr,
  output logic [DW-1:0]                  rd_data
);
  localparam int AW    = PAGE_BITS + OFFS_BITS;
  localparam int DEPTH = 1 << AW;
  localparam int PSIZE = 1 << OFFS_BITS;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  logic [DW-1:0]        mem  [DEPTH];
  logic [DW-1:0]        pbuf [PSIZE];
  logic [PSIZE-1:0]     vld;
  logic [PAGE_BITS-1:0] page;
  logic [OFFS_BITS-1:0] ptr;
  logic [CW-1:0]        cnt;

  wire take_commit = commit && !busy && (|vld);
  wire take_addr   = addr_load && !busy && !take_commit;
  wire take_byte   = byte_load && !busy && !take_commit && !addr_load;
  wire finish      = busy && (cnt == '0);

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (finish) begin
      for (int j = 0; j < PSIZE; j++)
        if (vld[j]) mem[{page, OFFS_BITS'(j)}] <= pbuf[j];
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) pbuf[ptr] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      vld  <= '0;
      page <= '0;
      ptr  <= '0;
    end else if (busy) begin
      if (finish) begin
        busy <= 1'b0;
        vld  <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (take_commit) begin
      busy <= 1'b1;
      cnt  <= CW'(WR_CYCLES - 1);
    end else if (take_addr) begin
      page <= addr_in[AW-1:OFFS_BITS];
      ptr  <= addr_in[OFFS_BITS-1:0];
      vld  <= '0;
    end else if (take_byte) begin
      vld[ptr] <= 1'b1;
      ptr      <= ptr + 1'b1;
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && !addr_load && !commit && !busy) |=> (ptr == $past(ptr) + 1'b1) && $stable(page)); // R3

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy && (cnt == $past(cnt) - 1'b1)); // R6

  AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vld == '0)); // R6

  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !busy && vld == '0) |=> !busy); // R8

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> $stable(page) && $stable(ptr) && $stable(vld)); // R7

  AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_load && !busy && !commit) |=> (vld == '0)); // R2
endmodule

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, byte_load = 1'b0, commit = 1'b0;
  logic [7:0] addr_in = '0, byte_in = '0, rd_addr = '0;
  logic busy;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  bit hold = 1'b0;
  string cur_req = "R1";

  int m_mem [256];
  int m_buf [16];
  bit m_vld [16];
  int m_page = 0, m_ptr = 0, m_cnt = 0;
  bit m_busy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_buffer #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_load(byte_load), .byte_in(byte_in), .commit(commit), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  // behavioural reference model
  always @(posedge clk) begin
    bit any;
    any = 1'b0;
    foreach (m_vld[k]) if (m_vld[k]) any = 1'b1;
    if (!rst_n) begin
      foreach (m_mem[k]) m_mem[k] = 255;
      foreach (m_vld[k]) m_vld[k] = 1'b0;
      m_busy = 1'b0; m_page = 0; m_ptr = 0; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == WRC) begin
        for (int k = 0; k < 16; k++)
          if (m_vld[k]) begin m_mem[m_page*16+k] = m_buf[k]; m_vld[k] = 1'b0; end
        m_busy = 1'b0;
      end
    end else if (commit && any) begin
      m_busy = 1'b1; m_cnt = 0;
    end else if (addr_load) begin
      m_page = addr_in / 16; m_ptr = addr_in % 16;
      foreach (m_vld[k]) m_vld[k] = 1'b0;
    end else if (byte_load) begin
      m_buf[m_ptr] = byte_in; m_vld[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % 16;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({cur_req, " busy"}, busy, m_busy);
      chk({cur_req, " rd_data R10"}, rd_data, m_mem[rd_addr]);
    end
    if (!hold) rd_addr <= rd_addr + 8'd7;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic peek(string req, int a, int exp);
    hold = 1'b1;
    @(negedge clk);
    rd_addr = 8'(a);
    #1;
    chk(req, rd_data, exp);
    hold = 1'b0;
  endtask

  task automatic do_addr(int a);
    @(negedge clk); addr_load = 1'b1; addr_in = 8'(a);
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic do_byte(int d);
    @(negedge clk); byte_load = 1'b1; byte_in = 8'(d);
    @(negedge clk); byte_load = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 busy after reset", busy, 0);
    peek("R1 erased byte 0x00", 8'h00, 8'hFF);
    peek("R1 erased byte 0xFF", 8'hFF, 8'hFF);

    cur_req = "R2";
    do_addr(8'h23);
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
    cur_req = "R6";
    do_commit();
    chk("R6 busy after commit", busy, 1);
    peek("R6 old data during busy", 8'h23, 8'hFF);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R6 busy length", n + 1, WRC);
    peek("R2 first byte at 0x23", 8'h23, 8'hA1);
    peek("R3 third byte at 0x25", 8'h25, 8'hA3);
    peek("R5 neighbour 0x22 kept", 8'h22, 8'hFF);
    peek("R5 neighbour 0x26 kept", 8'h26, 8'hFF);

    cur_req = "R4";
    do_addr(8'h5A);
    for (int i = 0; i < 20; i++) do_byte(8'h10 + i);
    do_commit();
    wait_idle();
    peek("R4 wrapped offset A", 8'h5A, 8'h20);
    peek("R4 wrapped offset D", 8'h5D, 8'h23);
    peek("R3 wrap offset F", 8'h5F, 8'h15);
    peek("R3 wrap offset 0", 8'h50, 8'h16);
    peek("R3 page kept, 0x60 untouched", 8'h60, 8'hFF);

    cur_req = "R8";
    do_addr(8'h80);
    do_commit();
    chk("R8 no busy on empty commit", busy, 0);
    peek("R8 no write", 8'h80, 8'hFF);

    cur_req = "R7";
    do_addr(8'h30); do_byte(8'h77);
    do_commit();
    do_addr(8'h70); do_byte(8'h55); do_byte(8'h56); do_commit();
    wait_idle();
    peek("R7 byte loaded while busy dropped", 8'h70, 8'hFF);
    peek("R7 page kept while busy", 8'h30, 8'h77);
    do_commit();
    chk("R7 flags cleared, commit idle", busy, 0);
    do_byte(8'h99); do_commit(); wait_idle();
    peek("R7 pointer not moved while busy", 8'h31, 8'h99);

    cur_req = "R9";
    do_addr(8'h90); do_byte(8'h42);
    @(negedge clk); commit = 1'b1; byte_load = 1'b1; byte_in = 8'hEE;
    @(negedge clk); commit = 1'b0; byte_load = 1'b0;
    wait_idle();
    peek("R9 commit wins over byte", 8'h90, 8'h42);
    peek("R9 same-cycle byte dropped", 8'h91, 8'hFF);
    @(negedge clk); addr_load = 1'b1; addr_in = 8'hB4; byte_load = 1'b1; byte_in = 8'h11;
    @(negedge clk); addr_load = 1'b0; byte_load = 1'b0;
    do_byte(8'h22); do_commit(); wait_idle();
    peek("R9 address beats byte", 8'hB4, 8'h22);

    cur_req = "R10";
    repeat (40) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule